// File: doc/BRIEF.md
# UART FIFO Control with DMA Ready Signalling

This block holds the receive and transmit byte queues of one UART channel, together with the control register that manages them. The serial side pushes received bytes into the receive queue and pops bytes to send from the transmit queue. The host side does the opposite. A write to the control register can empty either queue in one cycle, pick the receive trigger threshold, and choose how the two DMA request pins behave. The serial shift registers sit outside this block, so a clear touches only the queues.

Two active-low request pins tell a DMA controller when to move data. There is one pin for receive and one for transmit. In single-character signalling, the receive pin asks for service as soon as any byte is waiting, and the transmit pin asks for service only when the transmit queue is completely empty. In threshold signalling, the receive pin asks once the trigger level is reached or a timeout pulse arrives. It then keeps asking until the queue drains. The transmit pin asks whenever the transmit queue has a free slot.

Top module: `uart_fifo_dma`

## Requirements
- R1: After reset, both ready pins are 1, both counts are 0, rx_trig is 0 and ctl_rdata reads 0.
- R2: Each queue returns bytes in the order they were pushed, holds up to 16 bytes, and presents a popped byte on its dout port in the cycle after the pop.
- R3: A push to a full queue is dropped and the count stays 16. A pop from an empty queue leaves dout unchanged and the count at 0.
- R4: Writing the control register with bit 1 set empties the receive queue, so rx_count is 0 the cycle after the write. The transmit queue is untouched, and bit 1 reads back as 0.
- R5: Writing the control register with bit 2 set empties the transmit queue, so tx_count is 0 the cycle after the write. The receive queue is untouched, and bit 2 reads back as 0.
- R6: Control bits 7:6 select the receive threshold: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. rx_trig is 1 exactly when rx_count is at or above the selected threshold.
- R7: Threshold signalling applies only when control bit 0 and control bit 3 are both 1. Otherwise single-character signalling applies. ctl_rdata shows bit 0, bit 3 and bits 7:6 as written, and all other bits read as 0.
- R8: In single-character signalling, txrdy_n is 0 one cycle after tx_count becomes 0, and 1 one cycle after tx_count becomes nonzero.
- R9: In single-character signalling, rxrdy_n is 0 one cycle after rx_count becomes nonzero, and 1 one cycle after rx_count becomes 0.
- R10: In threshold signalling, txrdy_n is 1 one cycle after tx_count reaches 16, and 0 one cycle after a slot is free.
- R11: In threshold signalling, rxrdy_n drops one cycle after either of two events, provided the receive queue is not empty. The first event is rx_count reaching the threshold. The second is rx_timeout being sampled high. The pin then stays 0 until one cycle after rx_count becomes 0.
- R12: Control bits 5:4 have no effect on behaviour and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read-back |
| rx_push | input | 1 | Push rx_din into the receive queue |
| rx_din | input | 8 | Received byte |
| rx_pop | input | 1 | Pop one byte from the receive queue |
| rx_timeout | input | 1 | Receive timeout pulse |
| rx_dout | output | 8 | Last byte popped from the receive queue |
| rx_count | output | 5 | Receive queue occupancy |
| rx_trig | output | 1 | Receive occupancy at or above threshold |
| rxrdy_n | output | 1 | Receive DMA request, active low |
| tx_push | input | 1 | Push tx_din into the transmit queue |
| tx_din | input | 8 | Byte to transmit |
| tx_pop | input | 1 | Pop one byte from the transmit queue |
| tx_dout | output | 8 | Last byte popped from the transmit queue |
| tx_count | output | 5 | Transmit queue occupancy |
| txrdy_n | output | 1 | Transmit DMA request, active low |

## Verification
A corrupted pointer or count shows at the ports within one cycle: as a byte out of order on a dout port, or as a count that disagrees with a reference queue that is updated on the same edges. A wrong request pin state shows one cycle after the occupancy change that should have caused it, because both pins are registered from the counts. The most telling cases are the threshold boundary for each trigger code, the latch that holds the receive pin low after a timeout, and the transmit pin flipping between 15 and 16 bytes.

// File: rtl/uart_fifo_pkg.sv
// Shared types and field positions for the UART FIFO control block.
// Assumes an 8-bit control register laid out as decoded below.
package uart_fifo_pkg;

    localparam int BYTE_W    = 8;
    localparam int FEN_BIT   = 0;
    localparam int RXCLR_BIT = 1;
    localparam int TXCLR_BIT = 2;
    localparam int DMA_BIT   = 3;
    localparam int TRIG_LSB  = 6;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_sel_e;

    typedef struct packed {
        trig_sel_e trig;
        logic      dma_mode;
        logic      fifo_en;
    } fctl_t;

    // Map a trigger code to its byte threshold.
    function automatic int unsigned trig_level(trig_sel_e sel);
        case (sel)
            TRIG_1:  return 1;
            TRIG_4:  return 4;
            TRIG_8:  return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/byte_fifo.sv
// Synchronous byte queue with a registered read port.
// Pushes while full and pops while empty are ignored; clear has priority.
// Assumes one push and one pop port, both acting on the rising edge.
module byte_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic             full;
    logic             empty;
    logic             do_push;
    logic             do_pop;

    // Occupancy flags and accepted operations.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full && !clr;
        do_pop  = pop && !empty && !clr;
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointers, count and read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            dout   <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop) begin
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
                dout   <= mem[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && push && !pop && !clr) |=> (count == CW'(DEPTH)));
    // R3
    empty_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && pop && !push && !clr) |=> ($stable(dout) && count == '0));
    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));

endmodule

// File: rtl/fifo_ctl_reg.sv
// Control register: holds enable, signalling mode and trigger code, and
// turns the two clear bits into one-cycle pulses that never read back.
// Assumes the host writes with a single-cycle strobe.
module fifo_ctl_reg
    import uart_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    output fctl_t             cfg,
    output logic              rx_clr,
    output logic              tx_clr
);

    // Stored fields; bits 5:4 and the clear bits are not kept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{trig: TRIG_1, dma_mode: 1'b0, fifo_en: 1'b0};
        end else if (wr) begin
            cfg.fifo_en  <= wdata[FEN_BIT];
            cfg.dma_mode <= wdata[DMA_BIT];
            cfg.trig     <= trig_sel_e'(wdata[TRIG_LSB +: 2]);
        end
    end

    // Clear pulses act on the write edge itself.
    always_comb begin
        rx_clr = wr && wdata[RXCLR_BIT];
        tx_clr = wr && wdata[TXCLR_BIT];
    end

    // Read-back image with self-clearing and unused bits at 0.
    always_comb begin
        rdata                 = '0;
        rdata[FEN_BIT]        = cfg.fifo_en;
        rdata[DMA_BIT]        = cfg.dma_mode;
        rdata[TRIG_LSB +: 2]  = cfg.trig;
    end

    // R7
    ctl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (rdata[DMA_BIT] == $past(wdata[DMA_BIT]) && rdata[TRIG_LSB +: 2] == $past(wdata[TRIG_LSB +: 2])));

endmodule

// File: rtl/dma_ready_gen.sv
// Registered DMA request pins and the receive trigger flag.
// Assumes counts come from registers, so each pin lags its count by one cycle.
module dma_ready_gen
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  fctl_t         cfg,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          rx_timeout,
    output logic          rx_trig,
    output logic          rxrdy_n,
    output logic          txrdy_n
);

    logic mode1;
    logic rx_empty;

    // Signalling mode and threshold compare.
    always_comb begin
        mode1    = cfg.fifo_en && cfg.dma_mode;
        rx_empty = (rx_count == '0);
        rx_trig  = (32'(rx_count) >= trig_level(cfg.trig));
    end

    // Request pin state per signalling mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxrdy_n <= 1'b1;
            txrdy_n <= 1'b1;
        end else if (mode1) begin
            txrdy_n <= (tx_count == CW'(DEPTH));
            if (rx_empty)                    rxrdy_n <= 1'b1;
            else if (rx_trig || rx_timeout)  rxrdy_n <= 1'b0;
        end else begin
            txrdy_n <= (tx_count != '0);
            rxrdy_n <= rx_empty;
        end
    end

    // R9
    rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |=> rxrdy_n);
    // R9
    mode0_rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode1 && !rx_empty) |=> !rxrdy_n);
    // R10
    mode1_tx_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && tx_count == CW'(DEPTH)) |=> txrdy_n);
    // R10
    mode1_tx_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && tx_count != CW'(DEPTH)) |=> !txrdy_n);
    // R11
    mode1_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode1 && rx_timeout && !rx_empty) |=> !rxrdy_n);

endmodule

// File: rtl/uart_fifo_dma.sv
// Top of the UART FIFO control block: two byte queues, the control
// register and the DMA request pin logic. Serial shifting lives elsewhere.
module uart_fifo_dma
    import uart_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_wdata,
    output logic [BYTE_W-1:0] ctl_rdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_din,
    input  logic              rx_pop,
    input  logic              rx_timeout,
    output logic [BYTE_W-1:0] rx_dout,
    output logic [CW-1:0]     rx_count,
    output logic              rx_trig,
    output logic              rxrdy_n,
    input  logic              tx_push,
    input  logic [BYTE_W-1:0] tx_din,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_dout,
    output logic [CW-1:0]     tx_count,
    output logic              txrdy_n
);

    fctl_t cfg;
    logic  rx_clr;
    logic  tx_clr;

    fifo_ctl_reg u_ctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .rdata  (ctl_rdata),
        .cfg    (cfg),
        .rx_clr (rx_clr),
        .tx_clr (tx_clr)
    );

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rx_clr),
        .push  (rx_push),
        .din   (rx_din),
        .pop   (rx_pop),
        .dout  (rx_dout),
        .count (rx_count)
    );

    byte_fifo #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_clr),
        .push  (tx_push),
        .din   (tx_din),
        .pop   (tx_pop),
        .dout  (tx_dout),
        .count (tx_count)
    );

    dma_ready_gen #(.DEPTH(DEPTH)) u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg),
        .rx_count   (rx_count),
        .tx_count   (tx_count),
        .rx_timeout (rx_timeout),
        .rx_trig    (rx_trig),
        .rxrdy_n    (rxrdy_n),
        .txrdy_n    (txrdy_n)
    );

endmodule

// File: tb/uart_fifo_dma_test.sv
// Scoreboard bench: drivers feed a reference queue model on each rising
// edge, a monitor compares every output at the falling edge.
module uart_fifo_dma_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr;
    logic [7:0] ctl_wdata;
    logic [7:0] ctl_rdata;
    logic       rx_push, rx_pop, rx_timeout;
    logic [7:0] rx_din, rx_dout;
    logic [4:0] rx_count;
    logic       rx_trig, rxrdy_n;
    logic       tx_push, tx_pop;
    logic [7:0] tx_din, tx_dout;
    logic [4:0] tx_count;
    logic       txrdy_n;

    int vectors = 0;
    int errors  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    uart_fifo_dma uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .rx_push(rx_push), .rx_din(rx_din),
        .rx_pop(rx_pop), .rx_timeout(rx_timeout), .rx_dout(rx_dout),
        .rx_count(rx_count), .rx_trig(rx_trig), .rxrdy_n(rxrdy_n),
        .tx_push(tx_push), .tx_din(tx_din), .tx_pop(tx_pop),
        .tx_dout(tx_dout), .tx_count(tx_count), .txrdy_n(txrdy_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lvl(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    // Reference model, updated on the same edges as the design.
    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    logic [7:0] exp_rx, exp_tx;
    bit   chk_rx, chk_tx;
    bit   m_en, m_dma, m_rxr, m_txr;
    logic [1:0] m_trig;

    always @(posedge clk) begin
        int rn;
        int tn;
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_en = 0; m_dma = 0; m_trig = 0; m_rxr = 1; m_txr = 1;
            chk_rx = 0; chk_tx = 0;
        end else begin
            rn = rxq.size();
            tn = txq.size();
            if (m_en && m_dma) begin
                m_txr = (tn == DEPTH);
                if (rn == 0) m_rxr = 1;
                else if (rn >= lvl(m_trig) || rx_timeout) m_rxr = 0;
            end else begin
                m_txr = (tn != 0);
                m_rxr = (rn == 0);
            end
            chk_rx = 0;
            chk_tx = 0;
            if (ctl_wr && ctl_wdata[1]) rxq.delete();
            else begin
                if (rx_pop && rn > 0) begin exp_rx = rxq.pop_front(); chk_rx = 1; end
                if (rx_push && rn < DEPTH) rxq.push_back(rx_din);
            end
            if (ctl_wr && ctl_wdata[2]) txq.delete();
            else begin
                if (tx_pop && tn > 0) begin exp_tx = txq.pop_front(); chk_tx = 1; end
                if (tx_push && tn < DEPTH) txq.push_back(tx_din);
            end
            if (ctl_wr) begin
                m_en = ctl_wdata[0]; m_dma = ctl_wdata[3]; m_trig = ctl_wdata[7:6];
            end
        end
    end

    // Monitor: compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            check(rx_count == 5'(rxq.size()), "R2 rx_count", rx_count, rxq.size());
            check(tx_count == 5'(txq.size()), "R2 tx_count", tx_count, txq.size());
            check(rx_trig == (rxq.size() >= lvl(m_trig)), "R6 rx_trig", rx_trig, int'(rxq.size() >= lvl(m_trig)));
            check(rxrdy_n == m_rxr, (m_en && m_dma) ? "R11 rxrdy_n" : "R9 rxrdy_n", rxrdy_n, m_rxr);
            check(txrdy_n == m_txr, (m_en && m_dma) ? "R10 txrdy_n" : "R8 txrdy_n", txrdy_n, m_txr);
            if (chk_rx) check(rx_dout == exp_rx, "R2 rx_dout order", rx_dout, exp_rx);
            if (chk_tx) check(tx_dout == exp_tx, "R2 tx_dout order", tx_dout, exp_tx);
        end
    end

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    // Driver tasks: every task starts and ends at a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v; @(negedge clk); ctl_wr = 0;
    endtask
    task automatic push_rx(input logic [7:0] b);
        rx_push = 1; rx_din = b; @(negedge clk); rx_push = 0;
    endtask
    task automatic pop_rx();
        rx_pop = 1; @(negedge clk); rx_pop = 0;
    endtask
    task automatic push_tx(input logic [7:0] b);
        tx_push = 1; tx_din = b; @(negedge clk); tx_push = 0;
    endtask
    task automatic pop_tx();
        tx_pop = 1; @(negedge clk); tx_pop = 0;
    endtask

    initial begin
        logic [7:0] held;
        rst_n = 0; ctl_wr = 0; ctl_wdata = 0; rx_push = 0; rx_pop = 0;
        rx_timeout = 0; rx_din = 0; tx_push = 0; tx_pop = 0; tx_din = 0;
        idle(3);
        // R1 reset state
        check(rxrdy_n == 1 && txrdy_n == 1, "R1 pins", {rxrdy_n, txrdy_n}, 3);
        check(rx_count == 0 && tx_count == 0, "R1 counts", rx_count + tx_count, 0);
        check(ctl_rdata == 0 && rx_trig == 0, "R1 ctl/trig", ctl_rdata, 0);
        rst_n = 1;
        idle(2);

        // R8 R9 single-character mode traffic
        for (int i = 0; i < 5; i++) push_rx(8'h30 + 8'(i));
        idle(1);
        check(rxrdy_n == 0, "R9 rx request", rxrdy_n, 0);
        for (int i = 0; i < 5; i++) pop_rx();
        idle(1);
        check(rxrdy_n == 1, "R9 rx release", rxrdy_n, 1);
        push_tx(8'hA1);
        idle(1);
        check(txrdy_n == 1, "R8 tx release on load", txrdy_n, 1);
        push_tx(8'hA2); pop_tx(); pop_tx();
        idle(1);
        check(txrdy_n == 0, "R8 tx request on empty", txrdy_n, 0);

        // R3 overflow and underflow
        for (int i = 0; i < 20; i++) push_rx(8'(i * 7 + 1));
        check(rx_count == 16, "R3 full drop", rx_count, 16);
        for (int i = 0; i < 16; i++) pop_rx();
        held = rx_dout;
        pop_rx();
        check(rx_dout == held && rx_count == 0, "R3 empty pop hold", rx_dout, held);

        // simultaneous push and pop, R2
        push_rx(8'h55);
        rx_push = 1; rx_pop = 1; rx_din = 8'h66; @(negedge clk); rx_push = 0; rx_pop = 0;
        pop_rx();
        idle(1);

        // R4 R5 clears
        for (int i = 0; i < 4; i++) begin push_rx(8'hC0 + 8'(i)); push_tx(8'hD0 + 8'(i)); end
        wr_ctl(8'h02);
        check(rx_count == 0 && tx_count == 4, "R4 rx clear only", rx_count, 0);
        check(ctl_rdata[1] == 0, "R4 clear bit reads 0", ctl_rdata[1], 0);
        wr_ctl(8'h04);
        check(tx_count == 0, "R5 tx clear", tx_count, 0);
        check(ctl_rdata[2] == 0, "R5 clear bit reads 0", ctl_rdata[2], 0);
        idle(1);

        // R6 R11 thresholds in threshold signalling
        for (int s = 0; s < 4; s++) begin
            wr_ctl({2'(s), 2'b00, 4'b1011});
            for (int i = 0; i < lvl(2'(s)) - 1; i++) push_rx(8'(s * 16 + i));
            check(rx_trig == 0, "R6 below threshold", rx_trig, 0);
            idle(1);
            check(rxrdy_n == 1, "R11 no request below threshold", rxrdy_n, 1);
            push_rx(8'hEE);
            check(rx_trig == 1, "R6 at threshold", rx_trig, 1);
            idle(1);
            check(rxrdy_n == 0, "R11 request at threshold", rxrdy_n, 0);
            for (int i = 0; i < lvl(2'(s)) - 1; i++) pop_rx();
            idle(1);
            check(rxrdy_n == 0, "R11 held until empty", rxrdy_n, 0);
            pop_rx();
            idle(1);
            check(rxrdy_n == 1, "R11 release on empty", rxrdy_n, 1);
        end

        // R11 timeout
        wr_ctl(8'hC9);
        push_rx(8'h11); push_rx(8'h22);
        idle(1);
        check(rxrdy_n == 1, "R11 before timeout", rxrdy_n, 1);
        rx_timeout = 1; @(negedge clk); rx_timeout = 0;
        idle(1);
        check(rxrdy_n == 0, "R11 after timeout", rxrdy_n, 0);
        pop_rx(); pop_rx();
        idle(1);
        check(rxrdy_n == 1, "R11 release after timeout", rxrdy_n, 1);

        // R10 transmit full boundary
        for (int i = 0; i < 15; i++) push_tx(8'h80 + 8'(i));
        idle(1);
        check(txrdy_n == 0, "R10 one slot free", txrdy_n, 0);
        push_tx(8'h8F);
        idle(1);
        check(txrdy_n == 1, "R10 full", txrdy_n, 1);
        pop_tx();
        idle(1);
        check(txrdy_n == 0, "R10 slot freed", txrdy_n, 0);
        wr_ctl(8'h04);
        idle(1);

        // R7 mode bit without enable stays single-character
        wr_ctl(8'h08);
        check(ctl_rdata == 8'h08, "R7 readback", ctl_rdata, 8'h08);
        idle(1);
        check(txrdy_n == 0, "R7 mode0 tx empty", txrdy_n, 0);
        push_tx(8'h01);
        idle(1);
        check(txrdy_n == 1, "R7 mode0 tx loaded", txrdy_n, 1);
        wr_ctl(8'h01);
        check(ctl_rdata == 8'h01, "R7 enable only", ctl_rdata, 8'h01);
        idle(1);
        check(txrdy_n == 1, "R7 enable only is mode0", txrdy_n, 1);
        pop_tx();

        // R12 unused bits
        wr_ctl(8'hF9);
        check(ctl_rdata == 8'hC9, "R12 bits 5:4 read 0", ctl_rdata, 8'hC9);
        for (int i = 0; i < 13; i++) push_rx(8'h40 + 8'(i));
        idle(1);
        check(rxrdy_n == 1, "R12 threshold unchanged below 14", rxrdy_n, 1);
        push_rx(8'h4D);
        idle(1);
        check(rxrdy_n == 0, "R12 threshold 14 reached", rxrdy_n, 0);
        for (int i = 0; i < 14; i++) pop_rx();
        idle(2);

        finish_run();
    end

endmodule